// File: doc/BRIEF.md
# Time-Sliced Display Memory Access Controller

This block lets a host processor and the video refresh fetch share one display memory without an arbiter. It runs off the dot clock and divides every character period of `DOTS` dots into two fixed slots: a host slot made of the first `HOST_DOTS` dots, and a video slot made of the remaining dots. During the video slot the video address counter owns the shared address bus.

A host read, write or video-address-register load is captured on the first clock edge at which it is seen while the block is idle. It is carried out in the host slot of the next period that starts after the capture. Read data is held in an 8-bit holding register. A ready flag rises as the host window closes and stays up until the host removes its request.

Register loads use the same host slot. The value to load is driven onto the shared address bus for the whole host window. The load strobe fires one dot after the value becomes valid. The two low bits of the host data pick which of the three video address registers is loaded.

Top module: `dmem_slot_ctrl`

## Requirements
- R1: A dot counter wraps every `DOTS` (7) clocks and starts at dot 0 after reset. `vctr_oe` is low in dots 0..`HOST_DOTS`-1 (0..3) and high in dots 4..6 of every period.
- R2: A request is captured on the first rising edge at which it is present while nothing is pending and `host_ready` is low. Its access window is dots 0..3 of the first period that begins after that edge. A request raised in a cycle at dot p therefore starts its window 7-p cycles later.
- R3: During the window of a read or a write, `mem_cs` is high and `mem_addr` equals the captured host address. `mem_we` is high for all four dots of a write and low for a read.
- R4: For a read, `host_rdata` holds the memory word that was at the captured address by the cycle in which `host_ready` rises. `host_ready` rises in dot 4 of the window's period, 7-p+4 cycles after the request cycle.
- R5: `host_ready` stays low from capture until the window ends. It stays high while any request input is held, and it is low one cycle after all request inputs are low.
- R6: With no access in progress, `mem_cs` is low throughout dots 0..3 and memory is not touched.
- R7: In dots 4..6, `mem_cs` is high, `mem_we` is low and `mem_addr` follows `vid_addr`, whatever the host is doing.
- R8: For a register load, `reg_bus_oe` is high and `reg_bus` holds the captured host address through dots 0..3 of the window. `reg_sel` equals the captured `host_wdata[1:0]` (0 top of page, 1 row start, 2 cursor). `reg_load` pulses for one cycle, in dot 1.
- R9: A register load with `host_wdata[1:0]` = 3 produces no `reg_load` pulse but still completes with `host_ready`.
- R10: Only one request is held at a time. Changes to `host_addr` or `host_wdata` after capture do not affect the access. A request that is still held after `host_ready` rises does not start a second access.
- R11: When several request inputs are high together, write wins over read, and read wins over register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Host memory read request (level) |
| host_wr | input | 1 | Host memory write request (level) |
| host_ld | input | 1 | Host video address register load request (level) |
| host_addr | input | AW | Memory address, or the value for a register load |
| host_wdata | input | DW | Write data; bits [1:0] select the register for a load |
| host_rdata | output | DW | Read holding register |
| host_ready | output | 1 | Access complete handshake |
| vid_addr | input | AW | Video address counter value |
| vctr_oe | output | 1 | Video counter owns the shared address bus |
| mem_cs | output | 1 | Display memory select |
| mem_we | output | 1 | Display memory write enable |
| mem_addr | output | AW | Display memory address |
| mem_wdata | output | DW | Display memory write data |
| mem_rdata | input | DW | Display memory read data |
| reg_bus | output | AW | Value driven onto the shared address bus for a load |
| reg_bus_oe | output | 1 | Host value owns the shared address bus |
| reg_load | output | 1 | Video address register load strobe |
| reg_sel | output | 2 | Video address register select |

## Verification
Every result is tied to the dot at which the request was raised. With the request in a cycle at dot p, the window opens 7-p cycles later, the register strobe follows one cycle after that, and ready plus read data appear 7-p+4 cycles after the request. Ready drops one cycle after the request is removed. The bench tracks the dot phase itself from the moment reset is released. It sets inputs a few nanoseconds after each rising edge and compares every output in every cycle of an operation against these offsets. This exposes an early, late or doubled window directly. Requests are placed at each of the seven phases, and random address and data changes are made while an access is pending.

// File: rtl/dmem_slot_ctrl.sv
module dmem_slot_ctrl #(
  parameter int DOTS      = 7,
  parameter int HOST_DOTS = 4,
  parameter int LOAD_DOT  = 1,
  parameter int AW        = 10,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_ld,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  input  logic [AW-1:0] vid_addr,
  output logic          vctr_oe,
  output logic          mem_cs,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] reg_bus,
  output logic          reg_bus_oe,
  output logic          reg_load,
  output logic [1:0]    reg_sel
);

  localparam int CW = $clog2(DOTS);
  localparam logic [CW-1:0] LAST_DOT = CW'(DOTS - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(HOST_DOTS - 1);
  localparam logic [CW-1:0] VID_FIRST = CW'(HOST_DOTS);
  localparam logic [CW-1:0] STROBE_DOT = CW'(LOAD_DOT);

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_LD} op_e;

  logic [CW-1:0] dot_q;
  logic          pend_q, act_q, rdy_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  wire any_req    = host_rd | host_wr | host_ld;
  wire take       = any_req & ~pend_q & ~rdy_q;
  wire period_end = (dot_q == LAST_DOT);
  wire win_end    = act_q & (dot_q == WIN_LAST);
  wire host_mem   = act_q & (op_q != OP_LD);

  op_e op_nxt;
  always_comb begin
    if (host_wr)      op_nxt = OP_WR;
    else if (host_rd) op_nxt = OP_RD;
    else              op_nxt = OP_LD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot_q <= '0;
    else        dot_q <= period_end ? '0 : dot_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      op_q    <= OP_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      pend_q  <= 1'b1;
      op_q    <= op_nxt;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end else if (win_end) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_q <= 1'b0;
    else if (period_end) act_q <= pend_q | take;
    else if (win_end)    act_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else if (win_end) begin
      rdy_q <= 1'b1;
      if (op_q == OP_RD) rdata_q <= mem_rdata;
    end else if (rdy_q && !any_req) begin
      rdy_q <= 1'b0;
    end
  end

  assign vctr_oe    = (dot_q >= VID_FIRST);
  assign mem_cs     = vctr_oe | host_mem;
  assign mem_we     = host_mem & (op_q == OP_WR);
  assign mem_addr   = host_mem ? addr_q : vid_addr;
  assign mem_wdata  = wdata_q;
  assign reg_bus    = addr_q;
  assign reg_bus_oe = act_q & (op_q == OP_LD);
  assign reg_sel    = wdata_q[1:0];
  assign reg_load   = reg_bus_oe & (dot_q == STROBE_DOT) & (wdata_q[1:0] != 2'b11);
  assign host_rdata = rdata_q;
  assign host_ready = rdy_q;

endmodule

// File: rtl/dmem_slot_ctrl_chk.sv
module dmem_slot_ctrl_chk #(
  parameter int DOTS      = 7,
  parameter int HOST_DOTS = 4,
  parameter int AW        = 10,
  parameter int CW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic          host_wr,
  input logic          host_ld,
  input logic          host_ready,
  input logic          vctr_oe,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          reg_load,
  input logic          reg_bus_oe,
  input logic [CW-1:0] dot_q
);

  wire any_req = host_rd | host_wr | host_ld;

  a_r1_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vctr_oe) |-> (dot_q == CW'(HOST_DOTS)));

  a_r1_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q == CW'(DOTS - 1)) |=> (dot_q == '0));

  a_r7_no_write_in_video: assert property (@(posedge clk) disable iff (!rst_n)
    vctr_oe |-> !mem_we);

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(mem_addr));

  a_r4_ready_at_video_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> vctr_oe);

  a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && any_req) |=> host_ready);

  a_r5_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !any_req) |=> !host_ready);

  a_r8_load_within_drive: assert property (@(posedge clk) disable iff (!rst_n)
    reg_load |-> reg_bus_oe);

  a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_load |=> !reg_load);

endmodule

bind dmem_slot_ctrl dmem_slot_ctrl_chk #(
  .DOTS(DOTS), .HOST_DOTS(HOST_DOTS), .AW(AW), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_ld(host_ld), .host_ready(host_ready), .vctr_oe(vctr_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .reg_load(reg_load),
  .reg_bus_oe(reg_bus_oe), .dot_q(dot_q)
);

// File: tb/dmem_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmem_slot_ctrl_tb_top;
  localparam int DOTS = 7, HOST = 4, AW = 10, DW = 8;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_rd = 0, host_wr = 0, host_ld = 0;
  logic [AW-1:0] host_addr = '0, vid_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata, mem_wdata, mem_rdata;
  logic host_ready, vctr_oe, mem_cs, mem_we, reg_bus_oe, reg_load;
  logic [AW-1:0] mem_addr, reg_bus;
  logic [1:0] reg_sel;

  logic [DW-1:0] bmem [MEMN];
  logic [DW-1:0] em [MEMN];
  int checks = 0, errors = 0, ph = 0;

  always #4 clk = ~clk;

  dmem_slot_ctrl #(.DOTS(DOTS), .HOST_DOTS(HOST), .LOAD_DOT(1), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr), .host_ld(host_ld),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .vid_addr(vid_addr), .vctr_oe(vctr_oe), .mem_cs(mem_cs),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_bus(reg_bus), .reg_bus_oe(reg_bus_oe), .reg_load(reg_load), .reg_sel(reg_sel));

  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

  function automatic int win_start(input int p); return DOTS - p; endfunction
  function automatic int ready_at(input int p); return DOTS - p + HOST; endfunction
  function automatic int kind_of(input logic [2:0] m); // R11: wr > rd > ld
    return m[1] ? 1 : (m[0] ? 0 : 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #3;
    ph = (ph + 1) % DOTS;
    vid_addr = AW'($urandom);
    #1;
    chk("R1 vctr_oe phase", int'(vctr_oe), int'(ph >= HOST));
    if (ph >= HOST) begin
      chk("R7 video cs", int'(mem_cs), 1);
      chk("R7 video no we", int'(mem_we), 0);
      chk("R7 video addr", int'(mem_addr), int'(vid_addr));
    end
  endtask

  task automatic wait_phase(input int p);
    while (ph != p) step();
  endtask

  task automatic run_op(input logic [2:0] mask, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int hold);
    int k, p, ws, rdy;
    k = kind_of(mask);
    p = ph;
    ws = win_start(p);
    rdy = ready_at(p);
    {host_ld, host_wr, host_rd} = mask;
    host_addr = a; host_wdata = d;
    for (int i = 1; i <= rdy + hold; i++) begin
      step();
      if (i == 1 || i > rdy) begin  // R10: post-capture changes ignored
        host_addr = AW'($urandom); host_wdata = DW'($urandom);
      end
      chk("R2/R5 ready timing", int'(host_ready), int'(i >= rdy));
      if (ph < HOST) begin
        if (k != 2 && i >= ws && i < ws + HOST) begin
          chk("R3 window cs", int'(mem_cs), 1);
          chk("R3 window addr", int'(mem_addr), int'(a));
          chk("R3/R11 window we", int'(mem_we), int'(k == 1));
        end else begin
          chk("R6/R10 idle host slot", int'(mem_cs), 0);
        end
        if (k == 2 && i >= ws && i < ws + HOST) begin
          chk("R8 bus oe", int'(reg_bus_oe), 1);
          chk("R8 bus value", int'(reg_bus), int'(a));
          chk("R8 select", int'(reg_sel), int'(d[1:0]));
        end else begin
          chk("R8 bus idle", int'(reg_bus_oe), 0);
        end
      end
      chk("R8/R9 load strobe", int'(reg_load),
          int'(k == 2 && i == ws + 1 && d[1:0] != 2'b11));
      if (i == rdy && k == 0) chk("R4 read data", int'(host_rdata), int'(em[a]));
    end
    if (k == 1) em[a] = d;
    {host_ld, host_wr, host_rd} = 3'b000;
    step();
    chk("R5 ready release", int'(host_ready), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0243));
    for (int i = 0; i < MEMN; i++) begin
      bmem[i] = DW'(i * 37 + 11);
      em[i]   = DW'(i * 37 + 11);
    end
    repeat (3) @(posedge clk);
    #3;
    chk("R5 reset ready", int'(host_ready), 0);
    chk("R1 reset vctr_oe", int'(vctr_oe), 0);
    chk("R8 reset load", int'(reg_load), 0);
    chk("R3 reset we", int'(mem_we), 0);
    rst_n = 1'b1; ph = 0;
    // R6: idle periods
    for (int i = 0; i < 2 * DOTS; i++) begin
      step();
      if (ph < HOST) chk("R6 idle cs", int'(mem_cs), 0);
    end
    // R2: reads raised at every phase
    for (int p = 0; p < DOTS; p++) begin
      wait_phase(p);
      run_op(3'b001, AW'(p * 5 + 3), '0, p % 3);
    end
    // R3/R4: write then read back
    wait_phase(2); run_op(3'b010, AW'(100), 8'hA5, 0);
    run_op(3'b001, AW'(100), '0, 1);
    // R8/R9: each register select
    for (int s = 0; s < 4; s++) run_op(3'b100, AW'(200 + s), DW'(s | 8'h40), 0);
    // R11: priority
    run_op(3'b011, AW'(7), 8'h3C, 0);
    run_op(3'b001, AW'(7), '0, 0);
    run_op(3'b101, AW'(9), 8'h01, 0);
    // R10: request held long after ready
    run_op(3'b001, AW'(300), '0, 12);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(1, 7));
      repeat ($urandom_range(0, 4)) step();
      run_op(m, AW'($urandom_range(0, 15)), DW'($urandom), $urandom_range(0, 3));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule